// File: doc/BRIEF.md
# Register Remap Table Expander

This block keeps a small set of sparse key-value configuration entries, each saying "the register numbered K in the integer (or floating-point) file is to be treated as a vectorised register with these properties". From those entries it builds, purely combinationally, two dense lookup tables of 32 slots each, one per register file. An instruction decoder presents a register number and a file select and reads back the remapped register index, the element width, a vector flag, a packed (SIMD) flag and an enabled bit for that register.

Software fills the entries one at a time through a flat write port: an entry number and a 16-bit data word. There is no read side for software; the only observable view of the stored entries is the decoder lookup. Entries whose bank field holds the reserved value are kept in storage but are ignored during expansion, which is also how every entry starts after reset. Slots that no live entry targets come back with every field zero, which the decoder treats as a plain scalar register.

Top module: `remap_expander`

## Requirements
- R1: A write with `wrEn` high stores `wrData` into entry `wrIdx` at the clock edge; the data word is laid out as bit 0 file type, bits 5:1 register key, bits 10:6 target index, bits 12:11 element width, bit 13 bank, bit 14 vector flag, bit 15 packed flag.
- R2: An entry with file type 0 populates only the integer table (`lkFile`=0) and an entry with file type 1 populates only the floating-point table (`lkFile`=1).
- R3: Each table has 32 slots; an entry populates exactly the slot whose number equals its key, and a lookup reads the slot numbered `lkKey`.
- R4: A populated slot returns the entry's element width, vector flag and packed flag unchanged on `lkElWidth`, `lkVector` and `lkPacked`.
- R5: A populated slot returns on `lkRegIdx` the entry's target index plus its bank shifted left by 5; since only bank 0 populates, bit 5 of `lkRegIdx` is never set.
- R6: A populated slot returns `lkEnabled` high.
- R7: A slot that no live entry targets returns `lkEnabled` low and all other lookup outputs zero.
- R8: When several live entries share the same file type and key, the slot takes its fields from the entry with the highest entry number.
- R9: A lookup in the cycle after a write reflects the new entry; with no write, lookup outputs do not change while the query is held.
- R10: An entry written with bank 1 (reserved) is stored but populates no slot; writing it over a live entry removes that entry's mapping.
- R11: After reset every entry holds the reserved bank value, so every lookup in both files returns the R7 empty slot until a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Entry write strobe |
| wrIdx | input | 4 | Entry number to write |
| wrData | input | 16 | Entry contents (layout in R1) |
| lkFile | input | 1 | Lookup file select: 0 integer, 1 floating point |
| lkKey | input | 5 | Register number as found in the opcode |
| lkElWidth | output | 2 | Element width of the looked-up slot |
| lkRegIdx | output | 6 | Remapped register index |
| lkVector | output | 1 | Slot describes a vector register |
| lkPacked | output | 1 | Slot uses packed SIMD elements |
| lkEnabled | output | 1 | Slot is populated by a live entry |

## Verification
Because expansion is combinational from the stored entries, any wrong stored entry or wrong priority shows at the lookup outputs in the very cycle after the write that caused it, provided the query touches the affected slot. The bench therefore sweeps all 64 file/key pairs after each group of writes and checks every cycle against a behavioural model, so a corrupted entry, a misrouted file bit, a lost reserved-bank filter or an inverted priority walk surfaces within one sweep of 64 cycles. A fault that only breaks the hold behaviour is caught on cycles where the query is held without writes.

// File: rtl/remap_pkg.sv
package remap_pkg;

  localparam int unsigned KEY_W  = 5;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned EW_W   = 2;
  localparam int unsigned RIDX_W = IDX_W + 1;
  localparam int unsigned SLOTS  = 1 << KEY_W;
  localparam int unsigned FILES  = 2;

  // Entry word, least significant field last.
  typedef struct packed {
    logic             simd;
    logic             vec;
    logic             bank;
    logic [EW_W-1:0]  elWidth;
    logic [IDX_W-1:0] tgtIdx;
    logic [KEY_W-1:0] key;
    logic             fileFp;
  } entry_t;

  localparam int unsigned ENTRY_W = $bits(entry_t);

  typedef struct packed {
    logic              enabled;
    logic              simd;
    logic              vec;
    logic [EW_W-1:0]   elWidth;
    logic [RIDX_W-1:0] regIdx;
  } slot_t;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic load;
    logic live;
  } strobe_t;

  // Entry value held after reset: reserved bank, so not live.
  localparam entry_t ENTRY_RESET = '{bank: 1'b1, default: '0};

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int unsigned ENTRY_CNT = 16,
  localparam int unsigned SEL_W = (ENTRY_CNT > 1) ? $clog2(ENTRY_CNT) : 1
) (
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrIdx,
  input  logic [ENTRY_W-1:0] wrData,
  output strobe_t            strobe,
  output logic [ENTRY_CNT-1:0] entrySel
);

  entry_t wrEntry;
  logic   idxInRange;

  assign wrEntry    = entry_t'(wrData);
  assign idxInRange = (32'(wrIdx) < ENTRY_CNT);

  always_comb begin
    strobe      = '0;
    strobe.load = wrEn && idxInRange;
    // Only bank 0 is a valid bank; anything else parks the entry.
    strobe.live = (wrEntry.bank == 1'b0);
  end

  for (genvar e = 0; e < ENTRY_CNT; e++) begin : g_sel
    assign entrySel[e] = strobe.load && (wrIdx == SEL_W'(e));
  end

endmodule

// File: rtl/remap_datapath.sv
module remap_datapath
  import remap_pkg::*;
#(
  parameter int unsigned ENTRY_CNT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [ENTRY_CNT-1:0] entrySel,
  input  logic [ENTRY_W-1:0]   wrData,
  input  logic                 lkFile,
  input  logic [KEY_W-1:0]     lkKey,
  output slot_t                lkSlot
);

  entry_t entryQ [ENTRY_CNT];
  logic   liveQ  [ENTRY_CNT];
  slot_t  table_ [FILES][SLOTS];

  // Entry storage, one register per entry.
  for (genvar e = 0; e < ENTRY_CNT; e++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entryQ[e] <= ENTRY_RESET;
        liveQ[e]  <= 1'b0;
      end else if (entrySel[e]) begin
        entryQ[e] <= entry_t'(wrData);
        liveQ[e]  <= strobe.live;
      end
    end
  end

  // Dense expansion: walk entries in ascending order, later ones win.
  for (genvar f = 0; f < FILES; f++) begin : g_file
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_comb begin
        table_[f][s] = '0;
        for (int i = 0; i < ENTRY_CNT; i++) begin
          if (liveQ[i] && (entryQ[i].fileFp == 1'(f)) &&
              (entryQ[i].key == KEY_W'(s))) begin
            table_[f][s].enabled = 1'b1;
            table_[f][s].simd    = entryQ[i].simd;
            table_[f][s].vec     = entryQ[i].vec;
            table_[f][s].elWidth = entryQ[i].elWidth;
            table_[f][s].regIdx  = RIDX_W'(entryQ[i].tgtIdx) +
                                   (RIDX_W'(entryQ[i].bank) << IDX_W);
          end
        end
      end
    end
  end

  assign lkSlot = table_[lkFile][lkKey];

endmodule

// File: rtl/remap_expander.sv
module remap_expander
  import remap_pkg::*;
#(
  parameter int unsigned ENTRY_CNT = 16,
  localparam int unsigned SEL_W = (ENTRY_CNT > 1) ? $clog2(ENTRY_CNT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [SEL_W-1:0]    wrIdx,
  input  logic [ENTRY_W-1:0]  wrData,
  input  logic                lkFile,
  input  logic [KEY_W-1:0]    lkKey,
  output logic [EW_W-1:0]     lkElWidth,
  output logic [RIDX_W-1:0]   lkRegIdx,
  output logic                lkVector,
  output logic                lkPacked,
  output logic                lkEnabled
);

  strobe_t              strobe;
  logic [ENTRY_CNT-1:0] entrySel;
  slot_t                lkSlot;

  remap_ctrl #(.ENTRY_CNT(ENTRY_CNT)) u_ctrl (
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .strobe   (strobe),
    .entrySel (entrySel)
  );

  remap_datapath #(.ENTRY_CNT(ENTRY_CNT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .entrySel (entrySel),
    .wrData   (wrData),
    .lkFile   (lkFile),
    .lkKey    (lkKey),
    .lkSlot   (lkSlot)
  );

  assign lkElWidth = lkSlot.elWidth;
  assign lkRegIdx  = lkSlot.regIdx;
  assign lkVector  = lkSlot.vec;
  assign lkPacked  = lkSlot.simd;
  assign lkEnabled = lkSlot.enabled;

endmodule

// File: rtl/remap_chk.sv
module remap_chk
  import remap_pkg::*;
#(
  parameter int unsigned ENTRY_CNT = 16,
  localparam int unsigned SEL_W = (ENTRY_CNT > 1) ? $clog2(ENTRY_CNT) : 1
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [SEL_W-1:0]    wrIdx,
  input logic [ENTRY_W-1:0]  wrData,
  input logic                lkFile,
  input logic [KEY_W-1:0]    lkKey,
  input logic [EW_W-1:0]     lkElWidth,
  input logic [RIDX_W-1:0]   lkRegIdx,
  input logic                lkVector,
  input logic                lkPacked,
  input logic                lkEnabled
);

  entry_t wd;
  assign wd = entry_t'(wrData);

  // R7
  empty_slot_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lkEnabled |-> (lkElWidth == '0 && lkRegIdx == '0 && !lkVector && !lkPacked));

  // R5
  no_reserved_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkEnabled |-> (lkRegIdx[RIDX_W-1] == 1'b0));

  // R11
  reset_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !lkEnabled);

  // R9
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn) && $stable(lkFile) && $stable(lkKey)) |->
      ($stable(lkEnabled) && $stable(lkRegIdx) && $stable(lkElWidth) &&
       $stable(lkVector) && $stable(lkPacked)));

  // R8
  top_entry_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrIdx == SEL_W'(ENTRY_CNT - 1) && !wd.bank &&
     lkFile == wd.fileFp && lkKey == wd.key) |=>
      (!($stable(lkFile) && $stable(lkKey)) ||
       (lkEnabled && lkRegIdx == RIDX_W'($past(wd.tgtIdx)) &&
        lkElWidth == $past(wd.elWidth) && lkVector == $past(wd.vec) &&
        lkPacked == $past(wd.simd))));

  // R10
  reserved_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wd.bank) |=> (lkRegIdx[RIDX_W-1] == 1'b0));

endmodule

bind remap_expander remap_chk #(.ENTRY_CNT(ENTRY_CNT)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
  .lkFile(lkFile), .lkKey(lkKey), .lkElWidth(lkElWidth), .lkRegIdx(lkRegIdx),
  .lkVector(lkVector), .lkPacked(lkPacked), .lkEnabled(lkEnabled)
);

// File: tb/tb_remap_expander.sv
module tb_remap_expander;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [15:0] wrData = '0;
  logic        lkFile = 1'b0;
  logic [4:0]  lkKey = '0;
  logic [1:0]  lkElWidth;
  logic [5:0]  lkRegIdx;
  logic        lkVector, lkPacked, lkEnabled;

  int checks = 0;
  int fails  = 0;
  string tag = "R11";
  bit   done = 1'b0;
  int unsigned rng = 32'h1d2c3b4a;

  // Behavioural model: raw stored words.
  logic [15:0] mWord [16];

  always #5 clk = ~clk;

  remap_expander dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .lkFile(lkFile), .lkKey(lkKey), .lkElWidth(lkElWidth), .lkRegIdx(lkRegIdx),
    .lkVector(lkVector), .lkPacked(lkPacked), .lkEnabled(lkEnabled)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) mWord[i] = 16'h2000; // bank bit set
    end else if (wrEn) begin
      mWord[wrIdx] = wrData;
    end
  end

  // Expected {enabled, packed, vector, elWidth, regIdx}
  function automatic logic [10:0] expect_slot(logic file, logic [4:0] key);
    logic [10:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] w = mWord[i];
      if (w[13] == 1'b0 && w[0] == file && w[5:1] == key) begin
        r = {1'b1, w[15], w[14], w[12:11], 6'(w[10:6]) + (6'(w[13]) << 5)};
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] mk(logic fp, logic [4:0] key, logic [4:0] idx,
                                     logic [1:0] ew, logic bank, logic vec, logic pk);
    return {pk, vec, bank, ew, idx, key, fp};
  endfunction

  function automatic int unsigned nextRand();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  // One cycle: check outputs at negedge, then drive new inputs.
  task automatic step(logic we, logic [3:0] wi, logic [15:0] wdat,
                      logic f, logic [4:0] k);
    logic [10:0] exp, act;
    @(negedge clk);
    exp = expect_slot(lkFile, lkKey);
    act = {lkEnabled, lkPacked, lkVector, lkElWidth, lkRegIdx};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s file=%0d key=%0d actual=%h expected=%h",
               tag, lkFile, lkKey, act, exp);
    end
    wrEn = we; wrIdx = wi; wrData = wdat; lkFile = f; lkKey = k;
  endtask

  task automatic sweep();
    for (int q = 0; q < 64; q++) step(1'b0, '0, '0, q[5], q[4:0]);
    step(1'b0, '0, '0, 1'b0, '0);
  endtask

  task automatic wr(logic [3:0] wi, logic [15:0] wdat, logic f, logic [4:0] k);
    step(1'b1, wi, wdat, f, k);
    step(1'b0, '0, '0, f, k);   // R9: new mapping checked next cycle
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tag = "R11"; sweep();

    // R1 / R9: single integer entry, query it directly.
    tag = "R1";
    wr(4'd0, mk(1'b0, 5'd3, 5'd7, 2'd2, 1'b0, 1'b1, 1'b0), 1'b0, 5'd3);
    tag = "R9"; step(1'b0, '0, '0, 1'b0, 5'd3);
    // R2: same key in the floating-point file.
    tag = "R2";
    wr(4'd1, mk(1'b1, 5'd3, 5'd20, 2'd1, 1'b0, 1'b0, 1'b1), 1'b1, 5'd3);
    step(1'b0, '0, '0, 1'b0, 5'd3);
    sweep();

    // R3 / R4 / R5 / R6 / R7: fill all entries with varied fields.
    tag = "R4";
    for (int e = 0; e < 16; e++)
      wr(e[3:0], mk(e[0], 5'(e * 2 + 1), 5'(31 - e), e[1:0], 1'b0, e[1], e[2]),
         e[0], 5'(e * 2 + 1));
    tag = "R3"; sweep();
    tag = "R5"; step(1'b0, '0, '0, 1'b1, 5'd31);
    tag = "R6"; step(1'b0, '0, '0, 1'b0, 5'd1);
    tag = "R7"; step(1'b0, '0, '0, 1'b0, 5'd0);

    // R8: duplicates, higher entry wins.
    tag = "R8";
    wr(4'd2, mk(1'b0, 5'd9, 5'd4, 2'd3, 1'b0, 1'b1, 1'b1), 1'b0, 5'd9);
    wr(4'd9, mk(1'b0, 5'd9, 5'd11, 2'd0, 1'b0, 1'b0, 1'b0), 1'b0, 5'd9);
    wr(4'd15, mk(1'b0, 5'd9, 5'd25, 2'd1, 1'b0, 1'b1, 1'b0), 1'b0, 5'd9);
    sweep();

    // R10: reserved bank parks the entry, lower duplicate resurfaces.
    tag = "R10";
    wr(4'd15, mk(1'b0, 5'd9, 5'd25, 2'd1, 1'b1, 1'b1, 1'b0), 1'b0, 5'd9);
    wr(4'd9, mk(1'b0, 5'd9, 5'd11, 2'd0, 1'b1, 1'b0, 1'b0), 1'b0, 5'd9);
    sweep();

    // Mixed random traffic.
    tag = "R8";
    for (int n = 0; n < 600; n++) begin
      int unsigned r = nextRand();
      int unsigned d = nextRand();
      step(r[0] & r[1], r[7:4], {d[15:14], (d[13] & d[12] & d[11]), d[12:0]},
           r[8], r[13:9]);
    end
    tag = "R9"; step(1'b0, '0, '0, 1'b0, '0); sweep();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule